// File: doc/BRIEF.md
# Majority-Vote Serial Receiver with Two-Stage Buffer

This block receives asynchronous serial frames. It runs from a system clock and a clock-enable strobe `tick` that pulses sixteen times per bit period. The `rxd` line first passes through a two-flop synchronizer. In idle, a falling edge starts a frame. Each bit is then judged by a 2-of-3 vote over the samples taken at ticks 7, 8 and 9 of that bit. A start bit that loses the vote is treated as noise, and the receiver returns to idle.

Bits arrive least significant first and collect in a first-stage shift register. When the frame's stop bit has been voted, the frame moves into a holding register that software reads, and a one-cycle interrupt pulse is raised. The next frame can shift in while the holding register is still unread. If that frame completes before the holding register is read, the new frame is dropped and an overrun flag is set. Three frame formats are supported: 7 data bits, 8 data bits plus a parity bit, and 9 data bits. An 8-bit format without parity is also available. In the 9-bit format, a wake-up filter can suppress interrupts for frames whose ninth bit is 0.

Top module: `uart_mv_rx`

## Requirements
- R1: After reset, `full`, `overrun`, `irq`, `bit9_out`, `parity_err` and `framing_err` are 0 and `data_out` is 0x00.
- R2: Each bit, including the start bit, takes the 2-of-3 majority of the samples at ticks 7, 8 and 9 after the start edge. A disturbance that corrupts only one of those samples does not change the received value.
- R3: A low pulse on an idle line that does not win the start-bit vote produces no frame, no interrupt and no change to the holding register.
- R4: The `fmt` input selects the frame format. 2'b00 is 7 data bits, and `data_out[7]` reads 0. 2'b01 is 8 data bits. 2'b10 is 8 data bits plus a parity bit. 2'b11 is 9 data bits. Data bits arrive least significant first.
- R5: In format 2'b10, the parity bit appears on `bit9_out`. In format 2'b11, the ninth data bit appears on `bit9_out`. In the other formats `bit9_out` is 0.
- R6: In format 2'b10, `parity_err` is 1 when the parity over the eight data bits and the parity bit disagrees with `par_odd`. The check expects an even count of ones when `par_odd`=0 and an odd count when `par_odd`=1. In all other formats `parity_err` is 0.
- R7: `framing_err` is set for a stored frame whose stop bit votes 0, and cleared for a stored frame whose stop bit votes 1.
- R8: A stored frame sets `full`. A one-cycle `rd_data` pulse clears `full` unless a new frame is stored in the same cycle.
- R9: When a frame completes while `full` is 1 and no `rd_data` pulse arrives in that cycle, `overrun` is set. In that case `data_out`, `bit9_out` and the error flags keep their previous values.
- R10: `overrun` clears only when a `rd_data` pulse follows a `rd_status` pulse that was given while `overrun` was 1. A `rd_data` pulse on its own leaves it set.
- R11: `irq` is a one-cycle pulse in the cycle the holding register loads. In format 2'b11 with `wake_en`=1, no pulse is raised when the stored ninth bit is 0, although the frame is still stored.
- R12: A `rd_data` pulse in the same cycle as a frame completion frees the holding register. The new frame is then stored without overrun, and `full` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial input line, idle high |
| fmt | input | 2 | Frame format select |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| wake_en | input | 1 | Wake-up filter enable for 9-bit format |
| rd_data | input | 1 | Holding register read strobe |
| rd_status | input | 1 | Status read strobe |
| data_out | output | 8 | Holding register data |
| bit9_out | output | 1 | Stored parity or ninth bit |
| full | output | 1 | Holding register contains an unread frame |
| overrun | output | 1 | A frame was lost |
| parity_err | output | 1 | Parity mismatch on the stored frame |
| framing_err | output | 1 | Stop bit of the stored frame was 0 |
| irq | output | 1 | Receive interrupt pulse |

## Verification
Two events can land on the same clock edge: the completion of a frame and the software read of the holding register. When they coincide, the read must free the buffer, the new frame must be stored, and no overrun may be flagged. The bench first measures how many cycles after the start edge the interrupt appears for a frame aligned to a known tick phase. It then sends a second frame with the same alignment while the buffer is still full, and pulses `rd_data` in the cycle just before that measured edge. After the frame, the bench expects the new data in the holding register, `full` still at 1 and `overrun` at 0.

// File: rtl/uart_mv_rx.sv
module uart_mv_rx #(
  parameter int OVS      = 16,
  parameter int VOTE_MID = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] fmt,
  input  logic       par_odd,
  input  logic       wake_en,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic [7:0] data_out,
  output logic       bit9_out,
  output logic       full,
  output logic       overrun,
  output logic       parity_err,
  output logic       framing_err,
  output logic       irq
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] P0 = CW'(VOTE_MID - 1);
  localparam logic [CW-1:0] P1 = CW'(VOTE_MID);
  localparam logic [CW-1:0] P2 = CW'(VOTE_MID + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic          rx_m, rx_s, rx_d;
  logic [CW-1:0] cnt;
  logic [1:0]    smp;
  logic [3:0]    bidx, last_idx;
  logic [8:0]    sh, nxt_sh;
  logic [7:0]    new_d;
  logic          new_b9, vote_pt, bitv, done, store, lost, arm;

  assign vote_pt = tick && st != S_IDLE && cnt == P2;
  assign bitv    = (smp[0] & smp[1]) | (smp[0] & rx_s) | (smp[1] & rx_s);
  assign done    = vote_pt && st == S_STOP;
  assign store   = done && (!full || rd_data);
  assign lost    = done && full && !rd_data;
  assign nxt_sh  = {bitv, sh[8:1]};

  always_comb begin
    case (fmt)
      2'b00:   last_idx = 4'd6;
      2'b01:   last_idx = 4'd7;
      default: last_idx = 4'd8;
    endcase
  end

  always_comb begin
    case (fmt)
      2'b00:   begin new_d = {1'b0, sh[8:2]}; new_b9 = 1'b0;  end
      2'b01:   begin new_d = sh[8:1];         new_b9 = 1'b0;  end
      default: begin new_d = sh[7:0];         new_b9 = sh[8]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_d <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      rx_d <= rx_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      smp  <= '0;
      bidx <= '0;
      sh   <= '0;
    end else if (st == S_IDLE) begin
      if (rx_d && !rx_s) begin
        st  <= S_START;
        cnt <= '0;
      end
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      if (cnt == P0) smp[0] <= rx_s;
      if (cnt == P1) smp[1] <= rx_s;
      if (cnt == P2) begin
        case (st)
          S_START: begin
            st   <= bitv ? S_IDLE : S_DATA;
            bidx <= '0;
          end
          S_DATA: begin
            sh   <= nxt_sh;
            bidx <= bidx + 1'b1;
            if (bidx == last_idx) st <= S_STOP;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_out    <= '0;
      bit9_out    <= 1'b0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      full        <= 1'b0;
      irq         <= 1'b0;
    end else begin
      irq <= store && !(fmt == 2'b11 && wake_en && !new_b9);
      if (store) begin
        data_out    <= new_d;
        bit9_out    <= new_b9;
        parity_err  <= (fmt == 2'b10) && ((^{new_d, new_b9}) ^ par_odd);
        framing_err <= !bitv;
        full        <= 1'b1;
      end else if (rd_data) begin
        full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      arm     <= 1'b0;
    end else begin
      if (lost) overrun <= 1'b1;
      else if (rd_data && arm) overrun <= 1'b0;
      if (rd_status && overrun) arm <= 1'b1;
      else if (rd_data) arm <= 1'b0;
    end
  end

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R11
  AST_IRQ_FULL:  assert property (@(posedge clk) disable iff (!rst_n) irq |-> full); // R8
  AST_OVR_KEEP:  assert property (@(posedge clk) disable iff (!rst_n) $rose(overrun) |-> $stable(data_out) && $stable(bit9_out)); // R9
  AST_WAKE_GATE: assert property (@(posedge clk) disable iff (!rst_n) (irq && fmt == 2'b11 && wake_en) |-> bit9_out); // R11
  AST_RD_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n) ($past(rd_data) && !irq) |-> !full); // R8
  AST_SEVEN_MSB: assert property (@(posedge clk) disable iff (!rst_n) (irq && fmt == 2'b00) |-> !data_out[7]); // R4
endmodule

// File: tb/uart_mv_rx_bench.sv
module uart_mv_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BITCYC = 32;

  logic clk = 0, rst_n = 0, tick = 0, rxd = 1;
  logic [1:0] fmt = 2'b01;
  logic par_odd = 0, wake_en = 0, rd_data = 0, rd_status = 0;
  logic [7:0] data_out;
  logic bit9_out, full, overrun, parity_err, framing_err, irq;

  int errors = 0, checks = 0, irq_cnt = 0, cyc = 0, lat = 0, dummy = 0;
  bit done_flag = 0;

  uart_mv_rx u_uart_mv_rx (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    tick <= ~tick;
    if (rst_n && irq) irq_cnt++;
    if (rst_n && irq && !full) begin
      checks++; errors++;
      $display("FAIL R8: irq with full=%0d expected 1", full);
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic align();
    @(negedge clk);
    while (tick) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] val, input int nb, input logic stopv,
                      input int rd_at, input int gl_bit, output int irq_at);
    logic [10:0] bits;
    int idx = 0;
    irq_at = -1;
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) bits[i+1] = val[i];
    bits[nb+1] = stopv;
    align();
    for (int b = 0; b < nb + 3; b++) begin
      for (int c = 0; c < BITCYC; c++) begin
        logic v;
        v = (b <= nb + 1) ? bits[b] : 1'b1;
        if (b == gl_bit + 1 && (c == 16 || c == 17)) v = ~v;
        rxd = v;
        rd_data = (idx == rd_at);
        if (irq && irq_at < 0) irq_at = idx;
        idx++;
        @(negedge clk);
      end
    end
    rxd = 1;
    rd_data = 0;
    repeat (BITCYC) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_data = 1; @(negedge clk); rd_data = 0; @(negedge clk);
  endtask

  task automatic pulse_st();
    rd_status = 1; @(negedge clk); rd_status = 0; @(negedge clk);
  endtask

  int n0;

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 full", full, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 irq", irq, 0);
    chk("R1 data", data_out, 0);
    chk("R1 flags", {bit9_out, parity_err, framing_err}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    fmt = 2'b01; n0 = irq_cnt;
    send(9'h0A5, 8, 1, -1, -1, dummy);
    chk("R4 8-bit data", data_out, 8'hA5);
    chk("R8 full set", full, 1);
    chk("R11 one irq", irq_cnt - n0, 1);
    chk("R7 good stop", framing_err, 0);
    chk("R5 bit9 zero", bit9_out, 0);
    pulse_rd();
    chk("R8 read clears", full, 0);

    fmt = 2'b00;
    send(9'h0DA, 7, 1, -1, -1, dummy);
    chk("R4 7-bit data", data_out, 8'h5A);
    pulse_rd();

    fmt = 2'b10; par_odd = 0;
    send(9'h0A5, 9, 1, -1, -1, dummy);
    chk("R6 even ok", parity_err, 0);
    chk("R5 parity bit", bit9_out, 0);
    pulse_rd();
    send(9'h1A5, 9, 1, -1, -1, dummy);
    chk("R6 even bad", parity_err, 1);
    chk("R5 parity bit 1", bit9_out, 1);
    pulse_rd();
    par_odd = 1;
    send(9'h1A5, 9, 1, -1, -1, dummy);
    chk("R6 odd ok", parity_err, 0);
    pulse_rd();

    fmt = 2'b11;
    send(9'h1C3, 9, 1, -1, -1, dummy);
    chk("R4 9-bit data", data_out, 8'hC3);
    chk("R5 ninth bit", bit9_out, 1);
    chk("R6 no parity in 9-bit", parity_err, 0);
    pulse_rd();

    wake_en = 1; n0 = irq_cnt;
    send(9'h033, 9, 1, -1, -1, dummy);
    chk("R11 wake blocks irq", irq_cnt - n0, 0);
    chk("R11 wake still stores", data_out, 8'h33);
    pulse_rd();
    n0 = irq_cnt;
    send(9'h144, 9, 1, -1, -1, dummy);
    chk("R11 wake passes addr", irq_cnt - n0, 1);
    pulse_rd();
    wake_en = 0;

    fmt = 2'b01;
    send(9'h081, 8, 0, -1, -1, dummy);
    chk("R7 bad stop", framing_err, 1);
    pulse_rd();
    send(9'h081, 8, 1, -1, -1, dummy);
    chk("R7 stop cleared", framing_err, 0);
    pulse_rd();

    n0 = irq_cnt;
    align();
    rxd = 0; repeat (4) @(negedge clk); rxd = 1;
    repeat (12 * BITCYC) @(negedge clk);
    chk("R3 no irq on glitch", irq_cnt - n0, 0);
    chk("R3 no store on glitch", full, 0);
    send(9'h06C, 8, 1, -1, -1, dummy);
    chk("R3 frame after glitch", data_out, 8'h6C);
    pulse_rd();

    send(9'h0F0, 8, 1, -1, 2, dummy);
    chk("R2 vote hides glitch", data_out, 8'hF0);
    pulse_rd();

    send(9'h011, 8, 1, -1, -1, dummy);
    send(9'h022, 8, 1, -1, -1, dummy);
    chk("R9 overrun set", overrun, 1);
    chk("R9 data kept", data_out, 8'h11);
    pulse_rd();
    chk("R10 data read alone", overrun, 1);
    pulse_st();
    pulse_rd();
    chk("R10 cleared", overrun, 0);

    send(9'h03C, 8, 1, -1, -1, lat);
    chk("R12 latency seen", (lat > 0) ? 1 : 0, 1);
    n0 = irq_cnt;
    send(9'h096, 8, 1, lat - 1, -1, dummy);
    chk("R12 no overrun", overrun, 0);
    chk("R12 new data", data_out, 8'h96);
    chk("R12 full stays", full, 1);
    chk("R12 irq raised", irq_cnt - n0, 1);
    pulse_rd();
    chk("R8 final read", full, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule